// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock for an I2C master and the two timing strobes that the byte engine uses to move data. A 32-bit divisor word carries two 16-bit counts. The lower half sets the length of the SCL low phase and the upper half sets the length of the high phase. Each count unit spans a fixed number of input clocks, which is 8 by default. The SCL frequency is therefore the input clock divided by 8 times the sum of the two counts. Software normally loads both halves with the same value, rounded up, so the duty cycle is 50 %. Rates up to 400 kHz are supported, and 100 kHz is the usual setting.

The block runs only while both the enable input and the byte engine's run request are high. While it is stopped, SCL is released and no strobes appear. When it starts, it begins with a low phase and then alternates low and high phases without gaps. The data-change strobe marks the middle of every low phase, which is where SDA may be altered. The sample strobe marks the middle of every high phase, which is where SDA is read. The divisor is captured only when a low phase begins, so a write part-way through a cycle never distorts the pulse that is already running.

Top module: `scl_phase_gen`

## Requirements
- R1: While reset is held, or while `enable_i` or `run_i` is low, `scl_low_o`, `chg_stb_o` and `smp_stb_o` are all 0 from the cycle after the stop condition is seen, and they stay 0.
- R2: When the block is idle and sees `enable_i` and `run_i` both high at a clock edge, `scl_low_o` is 1 from that edge onward. The first low phase starts at once.
- R3: A low phase keeps `scl_low_o` at 1 for L*8 clock cycles. L is bits [15:0] of `div_cfg_i`, taken as an unsigned count.
- R4: A high phase keeps `scl_low_o` at 0 for H*8 clock cycles while running. H is bits [31:16] of `div_cfg_i`.
- R5: A count of 0 in either half is treated as 1, so that phase lasts 8 cycles.
- R6: `chg_stb_o` is high for exactly one cycle in each low phase. It fires at 0-based offset len/2 from the first low cycle, where len is the phase length in cycles.
- R7: `smp_stb_o` is high for exactly one cycle in each high phase. It fires at 0-based offset len/2 from the first high cycle.
- R8: Both halves of `div_cfg_i` are captured only on the edge that starts a low phase. A change made later affects neither the current low phase nor the high phase that follows it. The change takes effect at the next low phase.
- R9: A high phase is followed directly by the next low phase, so one SCL period lasts (L+H)*8 cycles.
- R10: If the run condition drops in the middle of a phase, SCL is released on the next cycle. When the run condition returns, the block starts a fresh, full-length low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Block enable |
| run_i | input | 1 | Run request from the byte engine |
| div_cfg_i | input | 32 | Divisor word: [15:0] low count, [31:16] high count |
| scl_low_o | output | 1 | 1 drives SCL low, 0 releases it |
| chg_stb_o | output | 1 | One-cycle strobe at the middle of each low phase |
| smp_stb_o | output | 1 | One-cycle strobe at the middle of each high phase |

## Verification
The assertions check properties that hold on every cycle:
- the quiet state after a stop and the immediate start of a low phase;
- the in-phase counter staying inside the latched length;
- latched lengths that are never zero and that do not change within a cycle;
- a handoff from low to high that happens only on the last low count;
- each strobe confined to its own phase.

Only the bench scenarios can show the absolute phase lengths in clocks for given divisor values, the zero-count clamp, and the exact position of each strobe within its phase. The same applies to the timing of a divisor change made part-way through a phase and to a full-length restart after the run request is dropped.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

endpackage

// File: rtl/sclgen_len_calc.sv
// Turns one 16-bit divisor half into a phase length in input clocks,
// with the zero count clamped to one unit.
module sclgen_len_calc #(
    parameter int HALF_W    = 16,
    parameter int UNIT_LOG2 = 3
) (
    input  logic [HALF_W-1:0]           count_i,
    output logic [HALF_W+UNIT_LOG2-1:0] len_o
);
    localparam logic [HALF_W-1:0] ONE_UNIT = HALF_W'(1);

    logic [HALF_W-1:0] eff_count;

    always_comb begin
        // R5: a count of zero acts as a count of one
        eff_count = (count_i == '0) ? ONE_UNIT : count_i;
        len_o     = {eff_count, {UNIT_LOG2{1'b0}}};
    end

endmodule

// File: rtl/sclgen_seq.sv
// Phase sequencer: idle -> low -> high -> low ... while active.
module sclgen_seq
    import sclgen_pkg::*;
#(
    parameter int HALF_W    = 16,
    parameter int UNIT_LOG2 = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          active_i,
    input  logic [HALF_W+UNIT_LOG2-1:0]   lo_len_i,
    input  logic [HALF_W+UNIT_LOG2-1:0]   hi_len_i,
    output phase_e                        phase_o,
    output logic [HALF_W+UNIT_LOG2-1:0]   cnt_o,
    output logic [HALF_W+UNIT_LOG2-1:0]   lo_len_o,
    output logic [HALF_W+UNIT_LOG2-1:0]   hi_len_o
);
    localparam int LEN_W = HALF_W + UNIT_LOG2;
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    typedef struct packed {
        phase_e           phase;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] lo_len;
        logic [LEN_W-1:0] hi_len;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!active_i) begin
            s_d.phase = PH_IDLE;
            s_d.cnt   = '0;
        end else begin
            unique case (s_q.phase)
                PH_IDLE: begin
                    s_d.phase  = PH_LOW;
                    s_d.cnt    = '0;
                    s_d.lo_len = lo_len_i;
                    s_d.hi_len = hi_len_i;
                end
                PH_LOW: begin
                    if (s_q.cnt == s_q.lo_len - ONE) begin
                        s_d.phase = PH_HIGH;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + ONE;
                    end
                end
                PH_HIGH: begin
                    if (s_q.cnt == s_q.hi_len - ONE) begin
                        s_d.phase  = PH_LOW;
                        s_d.cnt    = '0;
                        s_d.lo_len = lo_len_i;
                        s_d.hi_len = hi_len_i;
                    end else begin
                        s_d.cnt = s_q.cnt + ONE;
                    end
                end
                default: begin
                    s_d.phase = PH_IDLE;
                    s_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase  <= PH_IDLE;
            s_q.cnt    <= '0;
            s_q.lo_len <= '0;
            s_q.hi_len <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o  = s_q.phase;
    assign cnt_o    = s_q.cnt;
    assign lo_len_o = s_q.lo_len;
    assign hi_len_o = s_q.hi_len;

    a_r3_low_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_LOW) |-> (s_q.cnt < s_q.lo_len));

    a_r4_high_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_HIGH) |-> (s_q.cnt < s_q.hi_len));

    a_r5_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_IDLE) |-> (s_q.lo_len != '0 && s_q.hi_len != '0));

    a_r8_len_held: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_HIGH || (s_q.phase == PH_LOW && s_q.cnt != '0))
        |-> ($stable(s_q.lo_len) && $stable(s_q.hi_len)));

    a_r9_low_to_high: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_HIGH && $past(s_q.phase) == PH_LOW)
        |-> ($past(s_q.cnt) == $past(s_q.lo_len) - ONE));

endmodule

// File: rtl/sclgen_strobe.sv
// Decodes the sequencer state into the SCL drive and the mid-phase strobes.
module sclgen_strobe
    import sclgen_pkg::*;
#(
    parameter int HALF_W    = 16,
    parameter int UNIT_LOG2 = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  phase_e                      phase_i,
    input  logic [HALF_W+UNIT_LOG2-1:0] cnt_i,
    input  logic [HALF_W+UNIT_LOG2-1:0] lo_len_i,
    input  logic [HALF_W+UNIT_LOG2-1:0] hi_len_i,
    output logic                        scl_low_o,
    output logic                        chg_o,
    output logic                        smp_o
);
    logic [HALF_W+UNIT_LOG2-1:0] lo_mid, hi_mid;

    always_comb begin
        lo_mid    = lo_len_i >> 1;
        hi_mid    = hi_len_i >> 1;
        scl_low_o = (phase_i == PH_LOW);
        chg_o     = (phase_i == PH_LOW)  && (cnt_i == lo_mid);
        smp_o     = (phase_i == PH_HIGH) && (cnt_i == hi_mid);
    end

    a_r6_chg_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        chg_o |-> scl_low_o);

    a_r7_smp_in_high: assert property (@(posedge clk) disable iff (!rst_n)
        smp_o |-> (phase_i == PH_HIGH));

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
    import sclgen_pkg::*;
#(
    parameter int HALF_W    = 16,
    parameter int UNIT_LOG2 = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable_i,
    input  logic                  run_i,
    input  logic [2*HALF_W-1:0]   div_cfg_i,
    output logic                  scl_low_o,
    output logic                  chg_stb_o,
    output logic                  smp_stb_o
);
    localparam int LEN_W = HALF_W + UNIT_LOG2;

    logic             active;
    logic [LEN_W-1:0] half_len [2];
    phase_e           phase;
    logic [LEN_W-1:0] cnt, lo_len_q, hi_len_q;

    assign active = enable_i & run_i;

    // index 0: low half of the divisor, index 1: high half
    for (genvar h = 0; h < 2; h++) begin : g_half
        sclgen_len_calc #(
            .HALF_W    (HALF_W),
            .UNIT_LOG2 (UNIT_LOG2)
        ) u_len (
            .count_i (div_cfg_i[h*HALF_W +: HALF_W]),
            .len_o   (half_len[h])
        );
    end

    sclgen_seq #(
        .HALF_W    (HALF_W),
        .UNIT_LOG2 (UNIT_LOG2)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .lo_len_i (half_len[0]),
        .hi_len_i (half_len[1]),
        .phase_o  (phase),
        .cnt_o    (cnt),
        .lo_len_o (lo_len_q),
        .hi_len_o (hi_len_q)
    );

    sclgen_strobe #(
        .HALF_W    (HALF_W),
        .UNIT_LOG2 (UNIT_LOG2)
    ) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_i   (phase),
        .cnt_i     (cnt),
        .lo_len_i  (lo_len_q),
        .hi_len_i  (hi_len_q),
        .scl_low_o (scl_low_o),
        .chg_o     (chg_stb_o),
        .smp_o     (smp_stb_o)
    );

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!scl_low_o && !chg_stb_o && !smp_stb_o));

    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (active && phase == PH_IDLE) |=> scl_low_o);

endmodule

// File: tb/scl_phase_gen_bench.sv
module scl_phase_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        run = 1'b0;
    logic [31:0] div = '0;
    logic        scl_low, chg, smp;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 1'b0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    scl_phase_gen u_scl_phase_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (en),
        .run_i     (run),
        .div_cfg_i (div),
        .scl_low_o (scl_low),
        .chg_stb_o (chg),
        .smp_stb_o (smp)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int len_of(input int c);
        return ((c == 0) ? 1 : c) * 8;
    endfunction

    // Behavioural reference: phase code plus cycles left in the phase.
    int m_ph = 0;     // 0 stopped, 1 low, 2 high
    int m_left = 0;
    int m_lo = 8;
    int m_hi = 8;

    always @(posedge clk) begin
        if (!rst_n || !(en && run)) begin
            m_ph   = 0;
            m_left = 0;
        end else if (m_ph == 0 || (m_ph == 2 && m_left == 1)) begin
            m_ph   = 1;
            m_lo   = len_of(int'(div[15:0]));
            m_hi   = len_of(int'(div[31:16]));
            m_left = m_lo;
        end else if (m_ph == 1 && m_left == 1) begin
            m_ph   = 2;
            m_left = m_hi;
        end else begin
            m_left--;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            if (m_ph == 0) begin
                chk(!scl_low && !chg && !smp, "R1", {scl_low, chg, smp}, 0);
            end else if (m_ph == 1) begin
                chk(scl_low == 1'b1, "R3", scl_low, 1);
                chk(chg == (m_left == m_lo / 2), "R6", chg, (m_left == m_lo / 2));
                chk(!smp, "R7", smp, 0);
            end else begin
                chk(scl_low == 1'b0, "R4", scl_low, 0);
                chk(smp == (m_left == m_hi / 2), "R7", smp, (m_left == m_hi / 2));
                chk(!chg, "R6", chg, 0);
            end
        end
    end

    task automatic run_len(input logic lvl, output int n, output int nc, output int ns);
        n = 0; nc = 0; ns = 0;
        while (scl_low === lvl && n < 100000) begin
            n++;
            if (chg) nc++;
            if (smp) ns++;
            @(negedge clk);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int n, nc, ns, n_lo;
        repeat (3) @(negedge clk);
        chk(!scl_low && !chg && !smp, "R1", {scl_low, chg, smp}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;

        // R2/R3/R4/R6/R7: lo=2 -> 16 cycles, hi=3 -> 24 cycles
        div = {16'd3, 16'd2}; en = 1'b1; run = 1'b1;
        @(negedge clk);
        chk(scl_low == 1'b1, "R2", scl_low, 1);
        run_len(1'b1, n, nc, ns);
        chk(n == 16, "R3", n, 16);
        chk(nc == 1, "R6", nc, 1);
        run_len(1'b0, n, nc, ns);
        chk(n == 24, "R4", n, 24);
        chk(ns == 1, "R7", ns, 1);

        // R5: zero counts clamp to one unit
        run = 1'b0;
        @(negedge clk);
        chk(scl_low == 1'b0, "R10", scl_low, 0);
        div = 32'd0; run = 1'b1;
        @(negedge clk);
        run_len(1'b1, n, nc, ns);
        chk(n == 8, "R5", n, 8);
        chk(nc == 1, "R6", nc, 1);
        run_len(1'b0, n, nc, ns);
        chk(n == 8, "R5", n, 8);
        chk(ns == 1, "R7", ns, 1);

        // R8: divisor change mid low phase takes effect at the next low phase
        run = 1'b0;
        @(negedge clk);
        div = {16'd2, 16'd4}; run = 1'b1;
        @(negedge clk);
        repeat (3) @(negedge clk);
        div = {16'd1, 16'd1};
        run_len(1'b1, n, nc, ns);
        chk(n == 29, "R8", n, 29);
        run_len(1'b0, n, nc, ns);
        chk(n == 16, "R8", n, 16);
        run_len(1'b1, n, nc, ns);
        chk(n == 8, "R8", n, 8);
        run_len(1'b0, n, nc, ns);
        chk(n == 8, "R8", n, 8);

        // R9: lo=1, hi=5 -> period of 48 with no gap between phases
        div = {16'd5, 16'd1};
        run_len(1'b1, n, nc, ns);
        chk(n == 8, "R8", n, 8);
        run_len(1'b0, n, nc, ns);
        chk(n == 8, "R8", n, 8);
        run_len(1'b1, n_lo, nc, ns);
        run_len(1'b0, n, nc, ns);
        chk(n_lo + n == 48, "R9", n_lo + n, 48);
        chk(scl_low == 1'b1, "R9", scl_low, 1);

        // R10 / R1: drop run mid phase, hold enable low, then restart
        repeat (2) @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        chk(!scl_low && !chg && !smp, "R10", {scl_low, chg, smp}, 0);
        en = 1'b0; run = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!scl_low && !chg && !smp, "R1", {scl_low, chg, smp}, 0);
        end
        en = 1'b1;
        @(negedge clk);
        chk(scl_low == 1'b1, "R10", scl_low, 1);
        run_len(1'b1, n, nc, ns);
        chk(n == 8, "R10", n, 8);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule